// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is an I2C bus master controlled through a small word-addressed register interface. Software first loads a slave address byte (seven address bits plus a direction bit) and, for writes, a data byte. It then writes a single command value. The bits of that value request a START condition, a one-byte transfer and a STOP condition, in any combination. The controller runs the requested sequence on the wire, reports the outcome in a status register, and raises a maskable interrupt each time a data byte completes.

SCL and SDA are open-drain: the block only ever pulls a line low or releases it. It samples the resolved SDA level to read data, detect acknowledges and notice when another master wins arbitration. A command that tries to move data without first owning the bus does not reach the wire. It sets the error flag instead. Between commands the master keeps ownership and holds SCL low. This lets software split START, data and STOP across several command writes.

Top module: `i2c_byte_master`

## Requirements
- R1: Register word map (4-bit address): 0 slave address, 1 command (write) / status (read), 2 data, 3 clock period, 4 interrupt mask (bit 0), 5 raw interrupt (bit 0), 6 masked interrupt, 7 interrupt clear, 8 configuration (bit 4 = master enable). After reset the period register reads 1, all other registers read 0, and status reads 0x20 (idle only).
- R2: While master enable is 0, command writes are ignored: status is unchanged and the bus lines stay released.
- R3: A command that has no START bit while the master does not own the bus sets the error bit (0x02) and generates no bus activity.
- R4: Command bits are bit 1 START, bit 0 RUN (one byte) and bit 2 STOP, and they may be combined. START issues a (repeated) START condition and then the slave address byte, with address bit 0 = 1 meaning receive. STOP ends with a STOP condition, releases the bus and clears bus-busy (0x40). Without STOP, ownership persists for later commands.
- R5: On receive, the received byte is placed in the data register. The master ACKs it, or NACKs it when STOP was requested in the same command.
- R6: A missing ACK after the address byte sets address-nack (0x04) together with error (0x02), and the data byte is skipped.
- R7: A missing ACK after a transmitted data byte sets data-nack (0x08) together with error (0x02).
- R8: If SDA reads low while the master is releasing it for a 1 bit, the master sets arbitration-lost (0x10) and error, releases both lines and drops bus ownership.
- R9: Each completed data byte sets raw interrupt bit 0. The masked interrupt and the irq pin equal raw AND mask. Writing 1 to bit 0 of the clear register clears it. An address-only command sets no interrupt.
- R10: The SCL period is 20 × (period register + 1) clocks. SDA changes only while SCL is low, except within START and STOP conditions.
- R11: Status bit 0 (busy) is set while a command is running. Idle (0x20) is set only when the block is neither busy nor owning the bus, and bus-busy (0x40) tracks ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on bus_addr) |
| irq | output | 1 | Interrupt request, raw AND mask |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The bench attaches a behavioural slave to a wired-AND bus and runs directed scenarios. These cover an address that is not acknowledged, a data byte that is refused, and a receive that must end in a NACK because STOP shares the command. A design that confused these would report the wrong nack bit, would keep sending data after an address NACK, or would hold SDA low against the STOP. Further scenarios split START, RUN and STOP over separate writes, so that a master dropping ownership between commands would flag a spurious error. They also pull SDA low from a second source to force an arbitration loss, which a design that ignored the sampled line would miss while still driving SCL. The SCL period is measured against a non-default period value, which catches a divider off by one quarter.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int QUARTER_MULT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic       sda_in
);

  localparam int CW = $clog2(QUARTER_MULT * 256 + 1);
  localparam logic [3:0] A_SADDR = 4'd0, A_CMD = 4'd1, A_DATA = 4'd2, A_PERIOD = 4'd3,
                         A_MASK = 4'd4, A_RAW = 4'd5, A_MIS = 4'd6, A_ICLR = 4'd7,
                         A_CFG = 4'd8;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_ADDR, PH_DATA, PH_STOP} phase_t;

  logic [7:0] slave_q, data_q, period_q, shreg;
  logic       mask_q, raw_q, enable_q;
  logic       err_q, anack_q, dnack_q, arb_q, owned_q;
  logic       run_q, stop_q, sda_q;
  phase_t     ph;
  logic [1:0] qtr;
  logic [3:0] bitn;
  logic [CW-1:0] cnt;

  wire [CW-1:0] reload = CW'(QUARTER_MULT) * (CW'(period_q) + CW'(1)) - CW'(1);
  wire quarter_end = (cnt == '0);
  wire is_rx = slave_q[0];
  wire tx_now = (ph == PH_ADDR) || !is_rx;
  wire accept = bus_wr && (bus_addr == A_CMD) && enable_q && (ph == PH_IDLE);
  wire c_run = bus_wdata[0];
  wire c_start = bus_wdata[1];
  wire c_stop = bus_wdata[2];
  wire busy = (ph != PH_IDLE);
  wire idle = !busy && !owned_q;
  wire [7:0] status = {1'b0, owned_q, idle, arb_q, dnack_q, anack_q, err_q, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_q <= '0; data_q <= '0; period_q <= 8'd1; shreg <= '0;
      mask_q <= 1'b0; raw_q <= 1'b0; enable_q <= 1'b0;
      err_q <= 1'b0; anack_q <= 1'b0; dnack_q <= 1'b0; arb_q <= 1'b0; owned_q <= 1'b0;
      run_q <= 1'b0; stop_q <= 1'b0; sda_q <= 1'b0;
      ph <= PH_IDLE; qtr <= '0; bitn <= '0; cnt <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_SADDR:  slave_q <= bus_wdata;
          A_DATA:   data_q <= bus_wdata;
          A_PERIOD: period_q <= bus_wdata;
          A_MASK:   mask_q <= bus_wdata[0];
          A_ICLR:   if (bus_wdata[0]) raw_q <= 1'b0;
          A_CFG:    enable_q <= bus_wdata[4];
          default: ;
        endcase
      end

      if (accept) begin
        run_q <= c_run;
        stop_q <= c_stop;
        qtr <= '0;
        cnt <= reload;
        if (c_start) begin
          err_q <= 1'b0; anack_q <= 1'b0; dnack_q <= 1'b0; arb_q <= 1'b0;
          ph <= PH_START;
        end else if (owned_q) begin
          err_q <= 1'b0; anack_q <= 1'b0; dnack_q <= 1'b0;
          if (c_run) begin
            ph <= PH_DATA; shreg <= data_q; bitn <= '0;
          end else if (c_stop) begin
            ph <= PH_STOP;
          end
        end else begin
          err_q <= 1'b1;
        end
      end else if (busy) begin
        if (!quarter_end) begin
          cnt <= cnt - CW'(1);
        end else begin
          cnt <= reload;
          qtr <= qtr + 2'd1;
          case (ph)
            PH_START: begin
              if (qtr == 2'd0) sda_q <= 1'b0;
              if (qtr == 2'd2) sda_q <= 1'b1;
              if (qtr == 2'd3) begin
                owned_q <= 1'b1; ph <= PH_ADDR; shreg <= slave_q; bitn <= '0;
              end
            end
            PH_ADDR, PH_DATA: begin
              if (qtr == 2'd0) begin
                if (bitn < 4'd8) sda_q <= tx_now ? !shreg[7] : 1'b0;
                else             sda_q <= (ph == PH_DATA) && is_rx && !stop_q;
              end
              if (qtr == 2'd3) begin
                if (bitn < 4'd8) begin
                  if (tx_now && !sda_q && !sda_in) begin
                    arb_q <= 1'b1; err_q <= 1'b1; owned_q <= 1'b0;
                    sda_q <= 1'b0; ph <= PH_IDLE;
                  end else begin
                    shreg <= {shreg[6:0], sda_in};
                    bitn <= bitn + 4'd1;
                  end
                end else if (ph == PH_ADDR) begin
                  if (sda_in) begin
                    anack_q <= 1'b1; err_q <= 1'b1;
                    ph <= stop_q ? PH_STOP : PH_IDLE;
                  end else if (run_q) begin
                    ph <= PH_DATA; shreg <= data_q; bitn <= '0;
                  end else begin
                    ph <= stop_q ? PH_STOP : PH_IDLE;
                  end
                end else begin
                  raw_q <= 1'b1;
                  if (is_rx) data_q <= shreg;
                  else if (sda_in) begin
                    dnack_q <= 1'b1; err_q <= 1'b1;
                  end
                  ph <= stop_q ? PH_STOP : PH_IDLE;
                end
              end
            end
            PH_STOP: begin
              if (qtr == 2'd0) sda_q <= 1'b1;
              if (qtr == 2'd2) sda_q <= 1'b0;
              if (qtr == 2'd3) begin
                owned_q <= 1'b0; ph <= PH_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign scl_drive_low = (ph == PH_IDLE)  ? owned_q :
                         (ph == PH_START) ? (owned_q && (qtr < 2'd2)) :
                                            (qtr < 2'd2);
  assign sda_drive_low = sda_q;
  assign irq = raw_q & mask_q;

  always_comb begin
    case (bus_addr)
      A_SADDR:  bus_rdata = slave_q;
      A_CMD:    bus_rdata = status;
      A_DATA:   bus_rdata = data_q;
      A_PERIOD: bus_rdata = period_q;
      A_MASK:   bus_rdata = {7'b0, mask_q};
      A_RAW:    bus_rdata = {7'b0, raw_q};
      A_MIS:    bus_rdata = {7'b0, raw_q & mask_q};
      A_CFG:    bus_rdata = {3'b0, enable_q, 4'b0};
      default:  bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ph,
  input logic       owned,
  input logic       scl_low,
  input logic       sda_low,
  input logic       raw,
  input logic       anack,
  input logic       dnack,
  input logic       err,
  input logic       arb,
  input logic       enable,
  input logic       wr,
  input logic [3:0] addr
);

  AST_SDA_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && $past(!scl_low) && (sda_low != $past(sda_low))) |-> (ph == 3'd1 || ph == 3'd4)); // R10

  AST_RELEASED_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd0 && !owned) |-> (!scl_low && !sda_low)); // R4

  AST_STOP_DROPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph) == 3'd4 && ph == 3'd0) |-> !owned); // R4

  AST_IRQ_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> $past(ph) == 3'd3); // R9

  AST_ANACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(anack) |-> err); // R6

  AST_DNACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dnack) |-> err); // R7

  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb) |-> (!owned && !scl_low && !sda_low)); // R8

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 4'd1 && !enable && ph == 3'd0) |=> (ph == 3'd0 && $stable(err) && $stable(owned))); // R2

endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .owned(owned_q),
  .scl_low(scl_drive_low), .sda_low(sda_drive_low), .raw(raw_q),
  .anack(anack_q), .dnack(dnack_q), .err(err_q), .arb(arb_q),
  .enable(enable_q), .wr(bus_wr), .addr(bus_addr)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, scl_dl, sda_dl;
  logic slave_low = 1'b0;
  logic other_low = 1'b0;

  wire scl_line = ~scl_dl;
  wire sda_line = ~(sda_dl | slave_low | other_low);

  always #2 clk = ~clk;

  i2c_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .sda_in(sda_line)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  always @(negedge clk) cyc++;

  localparam logic [6:0] SLV = 7'h2C;
  logic [7:0] sl_sh = '0, sl_addr_seen = '0, sl_data_seen = '0, sl_tx = '0;
  int sl_bit = 0;
  int sl_starts = 0, sl_stops = 0;
  bit sl_in_addr = 0, sl_read = 0, sl_match = 0, sl_master_ack = 0, sl_data_ack_en = 1;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    sl_starts++; sl_bit = 0; sl_in_addr = 1; slave_low = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    sl_stops++; sl_bit = 0; sl_in_addr = 0; slave_low = 1'b0;
  end
  always @(posedge scl_line) begin
    if (sl_bit < 8) begin
      sl_sh = {sl_sh[6:0], sda_line};
      if (sl_bit == 7) begin
        if (sl_in_addr) begin
          sl_addr_seen = sl_sh; sl_read = sl_sh[0]; sl_match = (sl_sh[7:1] == SLV);
        end else if (!sl_read) sl_data_seen = sl_sh;
      end
    end else sl_master_ack = !sda_line;
    sl_bit++;
  end
  always @(negedge scl_line) begin
    if (sl_bit == 8) begin
      if (sl_in_addr) slave_low = sl_match;
      else if (!sl_read) slave_low = sl_data_ack_en;
      else slave_low = 1'b0;
    end else if (sl_bit == 9) begin
      bit go;
      go = sl_in_addr || sl_master_ack;
      slave_low = 1'b0; sl_bit = 0; sl_in_addr = 0;
      if (sl_read && sl_match && go) slave_low = !sl_tx[7];
    end else if (sl_read && sl_match && !sl_in_addr && sl_bit < 8 && sl_bit > 0) begin
      slave_low = !sl_tx[7 - sl_bit];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk); bus_addr = 4'd1; #1;
    while (bus_rdata[0] === 1'b1 && n < 20000) begin
      @(negedge clk); #1; n++;
    end
    chk("R11 busy clears", {31'b0, bus_rdata[0]}, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'd1, v); chk("R1 status after reset", v, 8'h20);
    rd(4'd3, v); chk("R1 period after reset", v, 8'h01);
    rd(4'd2, v); chk("R1 data after reset", v, 8'h00);
    rd(4'd5, v); chk("R1 raw after reset", v, 8'h00);
    chk("R1 lines released", {scl_dl, sda_dl, irq}, 3'b000);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    int s0 = sl_starts;
    wr(4'd0, 8'h58);
    wr(4'd1, 8'h07);
    repeat (100) @(negedge clk);
    rd(4'd1, v); chk("R2 status unchanged when disabled", v, 8'h20);
    chk("R2 no start on wire", sl_starts, s0);
    chk("R2 scl released", {31'b0, scl_dl}, 0);
  endtask

  task automatic t_no_owner();
    logic [7:0] v;
    int s0 = sl_starts;
    wr(4'd1, 8'h01);
    rd(4'd1, v); chk("R3 error without ownership", v, 8'h22);
    repeat (100) @(negedge clk);
    chk("R3 no bus activity", {sl_starts, 30'b0, scl_dl, sda_dl}, {s0, 32'b0});
  endtask

  task automatic t_write_combined();
    logic [7:0] v;
    int p0 = sl_stops;
    wr(4'd4, 8'h01);
    wr(4'd0, 8'h58); wr(4'd2, 8'hA5);
    wr(4'd1, 8'h07);
    repeat (3) @(negedge clk);
    rd(4'd1, v); chk("R11 busy during start", v, 8'h01);
    wait_done();
    chk("R4 address byte on wire", sl_addr_seen, 8'h58);
    chk("R4 data byte on wire", sl_data_seen, 8'hA5);
    chk("R4 stop seen", sl_stops, p0 + 1);
    rd(4'd1, v); chk("R4 bus free after stop", v, 8'h20);
    rd(4'd5, v); chk("R9 raw set after byte", v, 8'h01);
    rd(4'd6, v); chk("R9 masked set", v, 8'h01);
    chk("R9 irq high", {31'b0, irq}, 1);
    wr(4'd7, 8'h01);
    rd(4'd5, v); chk("R9 raw cleared", v, 8'h00);
    chk("R9 irq low after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_split();
    logic [7:0] v;
    int p0 = sl_stops;
    wr(4'd0, 8'h58);
    wr(4'd1, 8'h02);
    wait_done();
    rd(4'd1, v); chk("R11 owned after start only", v, 8'h40);
    rd(4'd5, v); chk("R9 no interrupt for address only", v, 8'h00);
    wr(4'd2, 8'h3C);
    wr(4'd1, 8'h01);
    wait_done();
    chk("R4 split data byte", sl_data_seen, 8'h3C);
    rd(4'd1, v); chk("R4 still owned after run", v, 8'h40);
    wr(4'd1, 8'h04);
    wait_done();
    rd(4'd1, v); chk("R4 released after stop", v, 8'h20);
    chk("R4 split stop seen", sl_stops, p0 + 1);
    wr(4'd7, 8'h01);
  endtask

  task automatic t_read();
    logic [7:0] v;
    wr(4'd0, 8'h59);
    sl_tx = 8'h96;
    wr(4'd1, 8'h03);
    wait_done();
    rd(4'd2, v); chk("R5 received byte", v, 8'h96);
    chk("R5 master acks without stop", {31'b0, sl_master_ack}, 1);
    rd(4'd1, v); chk("R5 owned after read", v, 8'h40);
    wr(4'd1, 8'h04);
    wait_done();
    sl_tx = 8'h4B;
    wr(4'd1, 8'h07);
    wait_done();
    rd(4'd2, v); chk("R5 received byte with stop", v, 8'h4B);
    chk("R5 master nacks with stop", {31'b0, sl_master_ack}, 0);
    rd(4'd1, v); chk("R5 released", v, 8'h20);
    wr(4'd7, 8'h01);
  endtask

  task automatic t_addr_nack();
    logic [7:0] v;
    wr(4'd0, 8'h5A);
    wr(4'd1, 8'h07);
    wait_done();
    rd(4'd1, v); chk("R6 address nack status", v, 8'h26);
    rd(4'd5, v); chk("R6 data skipped no interrupt", v, 8'h00);
  endtask

  task automatic t_data_nack();
    logic [7:0] v;
    sl_data_ack_en = 0;
    wr(4'd0, 8'h58); wr(4'd2, 8'h11);
    wr(4'd1, 8'h07);
    wait_done();
    rd(4'd1, v); chk("R7 data nack status", v, 8'h2A);
    rd(4'd5, v); chk("R9 raw set on refused byte", v, 8'h01);
    sl_data_ack_en = 1;
    wr(4'd4, 8'h00);
    rd(4'd6, v); chk("R9 masked off", v, 8'h00);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr(4'd7, 8'h01);
  endtask

  task automatic t_period();
    int t0, t1;
    wr(4'd3, 8'h03);
    wr(4'd0, 8'h58); wr(4'd2, 8'h77);
    wr(4'd1, 8'h07);
    @(posedge scl_line); t0 = cyc;
    @(posedge scl_line); t1 = cyc;
    chk("R10 scl period", t1 - t0, 80);
    wait_done();
    chk("R10 byte intact at slow clock", sl_data_seen, 8'h77);
    wr(4'd3, 8'h01);
    wr(4'd7, 8'h01);
  endtask

  task automatic t_arb();
    logic [7:0] v;
    other_low = 1'b1;
    wr(4'd0, 8'h58);
    wr(4'd1, 8'h07);
    wait_done();
    rd(4'd1, v); chk("R8 arbitration status", v, 8'h32);
    chk("R8 lines released", {scl_dl, sda_dl}, 2'b00);
    rd(4'd5, v); chk("R8 no interrupt", v, 8'h00);
    other_low = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    wr(4'd8, 8'h10);
    t_no_owner();
    t_write_combined();
    t_split();
    t_read();
    t_addr_nack();
    t_data_nack();
    t_period();
    t_arb();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

endmodule